// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small microcontroller core and its peripherals receive a clock. The CPU gives a one-cycle sleep strobe. A standby-select bit then picks the stopped state. With the bit clear, only the CPU clock stops and the system clock keeps running. With the bit set, the oscillator also stops and the I/O pins hold their levels until an external wake event arrives. After that wake the oscillator comes back first, and the CPU clock returns only when a programmable settling count has run out.

A hardware-standby pin forces the block into a fourth stopped state at once, from any state and without waiting for a clock edge. This state holds until a reset. Two controls are independent of the CPU-stopping states: a medium-speed enable that selects the divided clock for all bus masters, and a per-module stop mask that gates individual peripheral clocks. Either control can be active while the CPU runs normally.

Top module: `lms_top`

## Requirements
- R1: `mode` reports the state on every cycle with the code RUN=0, SLEEP=1, SW_STANDBY=2, HW_STANDBY=3. After reset it reads 0, and `cpu_clk_en` and `osc_en` are 1 while `io_hold` is 0.
- R2: In RUN, a `sleep_req` pulse with `standby_sel`=0 sets `mode` to 1 at the next clock edge. In that state `cpu_clk_en` is 0 and `osc_en` stays 1.
- R3: In RUN, a `sleep_req` pulse with `standby_sel`=1 sets `mode` to 2 at the next clock edge. In that state `cpu_clk_en` and `osc_en` are both 0, and every bit of `mod_clk_en` is 0.
- R4: `io_hold` is 1 from entry into software standby until the CPU clock is re-enabled. At all other times it is 0.
- R5: `clk_div_sel` equals the value `med_speed_en` had one clock earlier, and `cpu_clk_en` stays 1 in RUN whatever that value is. In hardware standby `clk_div_sel` is 0.
- R6: Bit i of `mod_clk_en` is 0 whenever bit i of `mod_stop_mask` is 1. Otherwise it is 1 in RUN and SLEEP. The mask never affects `cpu_clk_en`.
- R7: Medium-speed and module-stop can both be active at once while `mode` stays 0 and `cpu_clk_en` stays 1.
- R8: A high `hw_standby` sets `mode` to 3 without waiting for a clock edge and from any state. In that state `cpu_clk_en`, `osc_en`, `io_hold`, `clk_div_sel` and all bits of `mod_clk_en` are 0. The state persists after `hw_standby` falls, until `rst_n` is pulsed low.
- R9: In SLEEP, any bit set in both `irq_wake` and `irq_wake_en` returns `mode` to 0 and `cpu_clk_en` to 1 at the next clock edge. A wake bit whose enable is 0 has no effect.
- R10: In software standby only `ext_wake` wakes the block; `irq_wake` does not. `osc_en` is 1 from the first edge that samples `ext_wake`. `mode` stays 2 and `cpu_clk_en` stays 0 for `settle_cycles` further edges. The edge after those returns `mode` to 0 and `cpu_clk_en` to 1.
- R11: `sleep_req` is ignored in every stopped state, whatever `standby_sel` is. `mode` does not change because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_standby | input | 1 | Hardware standby request, asynchronous, active high |
| sleep_req | input | 1 | One-cycle sleep strobe from the CPU |
| standby_sel | input | 1 | 1 selects software standby, 0 selects sleep |
| settle_cycles | input | SETTLE_W (8) | Oscillator settling count used on wake from standby |
| med_speed_en | input | 1 | Selects the divided clock for bus masters |
| mod_stop_mask | input | NUM_MODULES (8) | 1 in bit i stops the clock of peripheral i |
| irq_wake | input | NUM_WAKE (4) | Interrupt wake events |
| irq_wake_en | input | NUM_WAKE (4) | Enables for each interrupt wake event |
| ext_wake | input | 1 | External wake event for software standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | System oscillator enable |
| mod_clk_en | output | NUM_MODULES (8) | Peripheral clock enables |
| clk_div_sel | output | 1 | 1 selects the divided clock for the CPU and other bus masters |
| io_hold | output | 1 | Holds the port pin levels |
| mode | output | 2 | Current mode code |

## Verification
The sleep strobe is tried with `standby_sel` at each value. These runs show whether the two stopped states are told apart by which enables drop. Wake is tried three ways: with an enabled interrupt, with a masked interrupt, and with an interrupt aimed at software standby. Together these show whether the enable gating works and whether only the external event ends standby. The settling count is tried at 0 and at 3, and the cycle of CPU-clock return is checked against the count at each. Strobes sent during each stopped state, and hardware standby raised from RUN, from SLEEP and from software standby, show that no state escapes its exit rule.

// File: rtl/lms_pkg.sv
package lms_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_STBY   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_HW     = 3'd4
  } lms_state_t;

  localparam logic [1:0] MODE_RUN    = 2'd0;
  localparam logic [1:0] MODE_SLEEP  = 2'd1;
  localparam logic [1:0] MODE_SWSTBY = 2'd2;
  localparam logic [1:0] MODE_HWSTBY = 2'd3;

  // Reported mode: settling still counts as software standby.
  function automatic logic [1:0] mode_code(lms_state_t s);
    case (s)
      ST_RUN:    return MODE_RUN;
      ST_SLEEP:  return MODE_SLEEP;
      ST_STBY,
      ST_SETTLE: return MODE_SWSTBY;
      default:   return MODE_HWSTBY;
    endcase
  endfunction

  function automatic logic cpu_runs(lms_state_t s);
    return s == ST_RUN;
  endfunction

  function automatic logic osc_runs(lms_state_t s);
    return (s == ST_RUN) || (s == ST_SLEEP) || (s == ST_SETTLE);
  endfunction

  function automatic logic periph_live(lms_state_t s);
    return (s == ST_RUN) || (s == ST_SLEEP);
  endfunction

  function automatic logic pins_held(lms_state_t s);
    return (s == ST_STBY) || (s == ST_SETTLE);
  endfunction

  // Cycles from the wake edge until the CPU clock is back.
  function automatic int unsigned wake_latency(int unsigned settle);
    return settle + 1;
  endfunction

endpackage

// File: rtl/lms_wake_detect.sv
module lms_wake_detect #(
  parameter int NUM_WAKE = 4
) (
  input  logic [NUM_WAKE-1:0] irq_wake,
  input  logic [NUM_WAKE-1:0] irq_wake_en,
  output logic                wake_hit
);
  logic [NUM_WAKE-1:0] qualified;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_qual
    assign qualified[i] = irq_wake[i] & irq_wake_en[i];
  end

  assign wake_hit = |qualified;
endmodule

// File: rtl/lms_settle_timer.sv
module lms_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  input  logic                count_en,
  output logic                expired
);
  logic [SETTLE_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        remain <= '0;
    else if (load)                     remain <= load_val;
    else if (count_en && remain != '0) remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/lms_fsm.sv
module lms_fsm
  import lms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_standby,
  input  logic       sleep_req,
  input  logic       standby_sel,
  input  logic       wake_hit,
  input  logic       ext_wake,
  input  logic       settle_expired,
  output lms_state_t state,
  output logic       sleep_accept,
  output logic       stby_accept,
  output logic       settle_start
);
  lms_state_t nxt;

  // The strobe only counts while running: this is what makes it ignored elsewhere.
  assign sleep_accept = (state == ST_RUN) && sleep_req && !standby_sel;
  assign stby_accept  = (state == ST_RUN) && sleep_req &&  standby_sel;
  assign settle_start = (state == ST_STBY) && ext_wake;

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN: begin
        if (sleep_accept)     nxt = ST_SLEEP;
        else if (stby_accept) nxt = ST_STBY;
      end
      ST_SLEEP:  if (wake_hit)       nxt = ST_RUN;
      ST_STBY:   if (settle_start)   nxt = ST_SETTLE;
      ST_SETTLE: if (settle_expired) nxt = ST_RUN;
      default:   nxt = ST_HW;
    endcase
  end

  // Hardware standby is an asynchronous set. Only reset leaves it.
  always_ff @(posedge clk or negedge rst_n or posedge hw_standby) begin
    if (!rst_n)          state <= ST_RUN;
    else if (hw_standby) state <= ST_HW;
    else                 state <= nxt;
  end
endmodule

// File: rtl/lms_clock_gates.sv
module lms_clock_gates
  import lms_pkg::*;
#(
  parameter int NUM_MODULES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  lms_state_t             state,
  input  logic                   med_speed_en,
  input  logic [NUM_MODULES-1:0] mod_stop_mask,
  output logic                   cpu_clk_en,
  output logic                   osc_en,
  output logic [NUM_MODULES-1:0] mod_clk_en,
  output logic                   clk_div_sel,
  output logic                   io_hold,
  output logic [1:0]             mode
);
  logic div_q;
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= med_speed_en;
  end

  assign live        = periph_live(state);
  assign cpu_clk_en  = cpu_runs(state);
  assign osc_en      = osc_runs(state);
  assign io_hold     = pins_held(state);
  assign mode        = mode_code(state);
  assign clk_div_sel = div_q && (state != ST_HW);

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mod
    assign mod_clk_en[m] = live && !mod_stop_mask[m];
  end
endmodule

// File: rtl/lms_top.sv
module lms_top
  import lms_pkg::*;
#(
  parameter int NUM_MODULES = 8,
  parameter int NUM_WAKE    = 4,
  parameter int SETTLE_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hw_standby,
  input  logic                   sleep_req,
  input  logic                   standby_sel,
  input  logic [SETTLE_W-1:0]    settle_cycles,
  input  logic                   med_speed_en,
  input  logic [NUM_MODULES-1:0] mod_stop_mask,
  input  logic [NUM_WAKE-1:0]    irq_wake,
  input  logic [NUM_WAKE-1:0]    irq_wake_en,
  input  logic                   ext_wake,
  output logic                   cpu_clk_en,
  output logic                   osc_en,
  output logic [NUM_MODULES-1:0] mod_clk_en,
  output logic                   clk_div_sel,
  output logic                   io_hold,
  output logic [1:0]             mode
);
  lms_state_t state;
  logic       wake_irq_hit;
  logic       settle_done;
  logic       sleep_accept;
  logic       stby_accept;
  logic       settle_start;
  logic       settling;

  assign settling = (state == ST_SETTLE);

  lms_wake_detect #(.NUM_WAKE(NUM_WAKE)) u_wake (
    .irq_wake    (irq_wake),
    .irq_wake_en (irq_wake_en),
    .wake_hit    (wake_irq_hit)
  );

  lms_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (settle_start),
    .load_val (settle_cycles),
    .count_en (settling),
    .expired  (settle_done)
  );

  lms_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .hw_standby     (hw_standby),
    .sleep_req      (sleep_req),
    .standby_sel    (standby_sel),
    .wake_hit       (wake_irq_hit),
    .ext_wake       (ext_wake),
    .settle_expired (settle_done),
    .state          (state),
    .sleep_accept   (sleep_accept),
    .stby_accept    (stby_accept),
    .settle_start   (settle_start)
  );

  lms_clock_gates #(.NUM_MODULES(NUM_MODULES)) u_gates (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .med_speed_en  (med_speed_en),
    .mod_stop_mask (mod_stop_mask),
    .cpu_clk_en    (cpu_clk_en),
    .osc_en        (osc_en),
    .mod_clk_en    (mod_clk_en),
    .clk_div_sel   (clk_div_sel),
    .io_hold       (io_hold),
    .mode          (mode)
  );
endmodule

// File: rtl/lms_checker.sv
module lms_checker #(
  parameter int NUM_MODULES = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   hw_standby,
  input logic                   sleep_req,
  input logic                   standby_sel,
  input logic                   med_speed_en,
  input logic                   ext_wake,
  input logic [NUM_MODULES-1:0] mod_stop_mask,
  input logic [NUM_MODULES-1:0] mod_clk_en,
  input logic                   wake_irq_hit,
  input logic                   cpu_clk_en,
  input logic                   osc_en,
  input logic                   io_hold,
  input logic                   clk_div_sel,
  input logic [1:0]             mode
);
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
    (mode == 2'd0 && sleep_req && !standby_sel) |=> (mode == 2'd1)); // R2
  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (!cpu_clk_en && osc_en)); // R2
  AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
    (mode == 2'd0 && sleep_req && standby_sel) |=> (mode == 2'd2 && !osc_en)); // R3
  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (io_hold && !cpu_clk_en)); // R4
  AST_NO_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |-> !io_hold); // R4
  AST_DIV_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
    (mode != 2'd3) |=> (clk_div_sel == $past(med_speed_en))); // R5
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((mod_clk_en & mod_stop_mask) == '0)); // R6
  AST_RUN_CPU_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> cpu_clk_en); // R7
  AST_HW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> (mode == 2'd3)); // R8
  AST_HW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (!cpu_clk_en && !osc_en && !io_hold && !clk_div_sel && mod_clk_en == '0)); // R8
  AST_HW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |-> (mode == 2'd3)); // R8
  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
    (mode == 2'd1 && wake_irq_hit) |=> (mode == 2'd0 && cpu_clk_en)); // R9
  AST_OSC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && $past(mode) == 2'd2) |-> $past(osc_en)); // R10
  AST_STBY_STAYS: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
    (mode == 2'd2 && !osc_en && !ext_wake) |=> (mode == 2'd2 && !osc_en)); // R11
endmodule

bind lms_top lms_checker #(.NUM_MODULES(NUM_MODULES)) u_lms_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .hw_standby    (hw_standby),
  .sleep_req     (sleep_req),
  .standby_sel   (standby_sel),
  .med_speed_en  (med_speed_en),
  .ext_wake      (ext_wake),
  .mod_stop_mask (mod_stop_mask),
  .mod_clk_en    (mod_clk_en),
  .wake_irq_hit  (wake_irq_hit),
  .cpu_clk_en    (cpu_clk_en),
  .osc_en        (osc_en),
  .io_hold       (io_hold),
  .clk_div_sel   (clk_div_sel),
  .mode          (mode)
);

// File: tb/lms_top_bench.sv
module lms_top_bench;
  localparam int NM = 8;
  localparam int NW = 4;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_standby = 1'b0;
  logic          sleep_req = 1'b0;
  logic          standby_sel = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic          med_speed_en = 1'b0;
  logic [NM-1:0] mod_stop_mask = '0;
  logic [NW-1:0] irq_wake = '0;
  logic [NW-1:0] irq_wake_en = '0;
  logic          ext_wake = 1'b0;
  logic          cpu_clk_en, osc_en, clk_div_sel, io_hold;
  logic [NM-1:0] mod_clk_en;
  logic [1:0]    mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lms_top u_lms_top (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sleep_req(sleep_req),
    .standby_sel(standby_sel), .settle_cycles(settle_cycles), .med_speed_en(med_speed_en),
    .mod_stop_mask(mod_stop_mask), .irq_wake(irq_wake), .irq_wake_en(irq_wake_en),
    .ext_wake(ext_wake), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .mod_clk_en(mod_clk_en),
    .clk_div_sel(clk_div_sel), .io_hold(io_hold), .mode(mode)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Advance one edge, then settle 1 ns past it.
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
  endtask

  task automatic strobe(logic sel);
    standby_sel = sel; sleep_req = 1'b1; step(); sleep_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "mode after reset", mode, 0);
    chk("R1", "cpu_clk_en after reset", cpu_clk_en, 1);
    chk("R1", "osc_en after reset", osc_en, 1);
    chk("R1", "io_hold after reset", io_hold, 0);
    chk("R6", "all modules on", mod_clk_en, 8'hFF);
  endtask

  task automatic t_sleep_wake();
    irq_wake_en = 4'b0100;
    strobe(1'b0);
    chk("R2", "mode sleep", mode, 1);
    chk("R2", "cpu off in sleep", cpu_clk_en, 0);
    chk("R2", "osc on in sleep", osc_en, 1);
    chk("R6", "modules run in sleep", mod_clk_en, 8'hFF);
    irq_wake = 4'b0010; step();
    chk("R9", "masked irq keeps sleep", mode, 1);
    irq_wake = 4'b0100; step(); irq_wake = '0;
    chk("R9", "enabled irq wakes", mode, 0);
    chk("R9", "cpu back after wake", cpu_clk_en, 1);
    irq_wake_en = '0;
  endtask

  task automatic t_standby(int unsigned n);
    settle_cycles = SW'(n);
    strobe(1'b1);
    chk("R3", "mode standby", mode, 2);
    chk("R3", "osc off", osc_en, 0);
    chk("R3", "cpu off", cpu_clk_en, 0);
    chk("R3", "modules off", mod_clk_en, 0);
    chk("R4", "io hold on", io_hold, 1);
    irq_wake_en = 4'hF; irq_wake = 4'hF; step(); irq_wake = '0; irq_wake_en = '0;
    chk("R10", "irq does not wake standby", mode, 2);
    ext_wake = 1'b1; step(); ext_wake = 1'b0;
    chk("R10", "osc first", osc_en, 1);
    chk("R10", "cpu still off at wake edge", cpu_clk_en, 0);
    for (int k = 0; k < int'(n); k++) begin
      step();
      chk("R10", "cpu off while settling", cpu_clk_en, 0);
      chk("R4", "hold during settle", io_hold, 1);
    end
    step();
    chk("R10", "cpu on after settle", cpu_clk_en, 1);
    chk("R10", "mode run after settle", mode, 0);
    chk("R4", "hold released", io_hold, 0);
  endtask

  task automatic t_ignore();
    strobe(1'b1);
    strobe(1'b0);
    chk("R11", "strobe ignored in standby", mode, 2);
    chk("R11", "osc stays off", osc_en, 0);
    settle_cycles = '0; ext_wake = 1'b1; step(); ext_wake = 1'b0; step();
    strobe(1'b0);
    strobe(1'b1);
    chk("R11", "strobe ignored in sleep", mode, 1);
    chk("R11", "osc still on in sleep", osc_en, 1);
    irq_wake_en = 4'b0001; irq_wake = 4'b0001; step(); irq_wake = '0; irq_wake_en = '0;
    chk("R9", "back to run", mode, 0);
  endtask

  task automatic t_speed_mask();
    med_speed_en = 1'b1; mod_stop_mask = 8'hA5;
    #1;
    chk("R5", "divider not yet selected", clk_div_sel, 0);
    chk("R6", "mask gates modules", mod_clk_en, 8'h5A);
    step();
    chk("R5", "divider selected", clk_div_sel, 1);
    chk("R7", "cpu runs with both", cpu_clk_en, 1);
    chk("R7", "mode run with both", mode, 0);
    med_speed_en = 1'b0; step();
    chk("R5", "divider released", clk_div_sel, 0);
    mod_stop_mask = 8'hFF; #1;
    chk("R6", "full mask cpu on", cpu_clk_en, 1);
    mod_stop_mask = '0;
    med_speed_en = 1'b1; step();
  endtask

  task automatic t_hw(int unsigned from);
    if (from == 1) strobe(1'b0);
    if (from == 2) strobe(1'b1);
    #1; hw_standby = 1'b1; #0.5;
    chk("R8", "async entry", mode, 3);
    chk("R8", "cpu off", cpu_clk_en, 0);
    chk("R8", "osc off", osc_en, 0);
    chk("R8", "no div, no hold", {clk_div_sel, io_hold}, 0);
    chk("R8", "modules off", mod_clk_en, 0);
    step(); hw_standby = 1'b0; step(); step();
    ext_wake = 1'b1; irq_wake_en = 4'hF; irq_wake = 4'hF; strobe(1'b0);
    ext_wake = 1'b0; irq_wake = '0; irq_wake_en = '0;
    chk("R8", "sticky after release", mode, 3);
    do_reset();
    chk("R8", "reset leaves hw standby", mode, 0);
  endtask

  initial begin
    step();
    t_reset();
    t_sleep_wake();
    t_standby(3);
    t_standby(0);
    t_ignore();
    t_speed_mask();
    t_hw(0);
    t_hw(1);
    t_hw(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule